// File: doc/BRIEF.md
# Fractional-Ratio Reference Clock Enable Generator

This block turns a fast source clock into several single-cycle enable streams. Each stream has an average rate of the source rate times 18 divided by a 6-bit ratio value R. R is limited to 18 through 35, so every stream runs between the full source rate and a little over half of it. For example, R = 30 gives 18 enables in every 30 source cycles, which is 288 MHz from a 480 MHz source. Dividers further down the chip qualify their logic with these enables instead of using a new clock.

All channels share one control word. Channel i owns byte i of that word, which holds its ratio and a stop bit. A byte-enable vector chooses which bytes a write updates. An out-of-range ratio is clamped to the nearest legal value and raises a per-channel range flag. The word reads back with the clamped values in it. A new ratio is used only from the next enable pulse on, so no enable interval is ever cut short. While a channel is stopped, its enable stays low and its phase is kept.

Top module: `clkfrac_top`

## Requirements
- R1: After reset every ref_en bit is low, every range_err bit is low, and every byte of cfg_rdata reads 0x92 (ratio 18, stop bit set).
- R2: Channel i uses byte i of the control word. Bits [8i+5:8i] hold the ratio, bit 8i+7 is the stop bit (1 = stopped), and bit 8i+6 always reads 0. A write with cfg_we high updates only the bytes whose cfg_be bit is 1; all other bytes keep their value.
- R3: While a channel runs with ratio R in 18..35, any R consecutive running cycles contain exactly 18 enable pulses.
- R4: With ratio 18, ref_en is high in every running cycle.
- R5: A running channel never goes two consecutive running cycles without an enable pulse.
- R6: A written ratio below 18 is stored and read back as 18. A written ratio above 35 is stored and read back as 35.
- R7: Each write to byte i sets range_err[i] to 1 if the written ratio is outside 18..35 and to 0 if it is inside. Between writes to byte i, range_err[i] holds its value.
- R8: The stop bit takes effect at the edge after the write. While the channel is stopped, ref_en stays low and the phase is held. Pulses counted over running cycles on both sides of a stopped interval add up as if the channel had never stopped.
- R9: A new ratio is used only from the first enable pulse after the write. Example: a channel that runs at ratio 18 from reset is rewritten to 35. It pulses at the write edge and at the next edge, then shows one low cycle, then pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_be | input | NUM_OUT | Per-byte write select |
| cfg_wdata | input | 8*NUM_OUT | Control word write data |
| cfg_rdata | output | 8*NUM_OUT | Stored control word with clamped ratios |
| ref_en | output | NUM_OUT | Registered single-cycle enable, one bit per channel |
| range_err | output | NUM_OUT | Set when the last write to that byte held an illegal ratio |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least two cycles, so the two-deep history of the stop bits starts from the stopped state.
- cfg_we, cfg_be and cfg_wdata never carry unknown values after reset.
- Writes may arrive on any cycle, including back to back.

The bench drives every input from negedge-aligned tasks and keeps it defined from time zero. It sweeps all 64 ratio codes across four channels at once, with each channel holding a different offset of the code. This covers clamping on both sides, the exact pulse count per window, and the spacing rule. Separate directed sequences check byte-select isolation, the pulse timing of a ratio change, and phase hold across a stop.

// File: rtl/clkfrac_pkg.sv
package clkfrac_pkg;
  localparam int RATIO_W  = 6;
  localparam int STEP     = 18;
  localparam int RMIN     = 18;
  localparam int RMAX     = 35;
  localparam int BYTE_W   = 8;
  localparam int STOP_BIT = 7;

  function automatic logic ratio_bad(input logic [RATIO_W-1:0] r);
    return (r < RATIO_W'(RMIN)) || (r > RATIO_W'(RMAX));
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_clamp(input logic [RATIO_W-1:0] r);
    if (r < RATIO_W'(RMIN)) return RATIO_W'(RMIN);
    if (r > RATIO_W'(RMAX)) return RATIO_W'(RMAX);
    return r;
  endfunction
endpackage

// File: rtl/clkfrac_regs.sv
module clkfrac_regs
  import clkfrac_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [NUM_OUT-1:0]                 be,
  input  logic [NUM_OUT*BYTE_W-1:0]          wdata,
  output logic [NUM_OUT-1:0][RATIO_W-1:0]    ratio_o,
  output logic [NUM_OUT-1:0]                 stop_o,
  output logic [NUM_OUT-1:0]                 err_o,
  output logic [NUM_OUT*BYTE_W-1:0]          rdata
);
  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(RMIN);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_byte
    logic [RATIO_W-1:0] wr_ratio;
    assign wr_ratio = wdata[i*BYTE_W +: RATIO_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        ratio_o[i] <= RESET_RATIO;
        stop_o[i]  <= 1'b1;
        err_o[i]   <= 1'b0;
      end else if (we && be[i]) begin
        ratio_o[i] <= ratio_clamp(wr_ratio);
        stop_o[i]  <= wdata[i*BYTE_W + STOP_BIT];
        err_o[i]   <= ratio_bad(wr_ratio);
      end
    end

    assign rdata[i*BYTE_W +: BYTE_W] = {stop_o[i], 1'b0, ratio_o[i]};
  end
endmodule

// File: rtl/clkfrac_accum.sv
module clkfrac_accum
  import clkfrac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stop,
  input  logic [RATIO_W-1:0] ratio_pend,
  output logic               en_o,
  output logic [RATIO_W-1:0] ratio_act_o
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] phase_q;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   rem;
  logic               wrap;

  // The phase stays below the active ratio and the ratio is at least STEP,
  // so one subtraction per cycle is always enough.
  always_comb begin
    sum  = {1'b0, phase_q} + SUM_W'(STEP);
    wrap = sum >= {1'b0, ratio_act_o};
    rem  = sum - {1'b0, ratio_act_o};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= '0;
      ratio_act_o <= RATIO_W'(RMIN);
      en_o        <= 1'b0;
    end else if (stop) begin
      en_o <= 1'b0;
    end else begin
      en_o <= wrap;
      if (wrap) begin
        phase_q     <= rem[RATIO_W-1:0];
        ratio_act_o <= ratio_pend;
      end else begin
        phase_q <= sum[RATIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/clkfrac_top.sv
module clkfrac_top
  import clkfrac_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [NUM_OUT-1:0]          cfg_be,
  input  logic [NUM_OUT*8-1:0]        cfg_wdata,
  output logic [NUM_OUT*8-1:0]        cfg_rdata,
  output logic [NUM_OUT-1:0]          ref_en,
  output logic [NUM_OUT-1:0]          range_err
);
  logic [NUM_OUT-1:0][RATIO_W-1:0] ratio_w;
  logic [NUM_OUT-1:0][RATIO_W-1:0] act_w;
  logic [NUM_OUT-1:0]              stop_w;

  clkfrac_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .ratio_o (ratio_w),
    .stop_o  (stop_w),
    .err_o   (range_err),
    .rdata   (cfg_rdata)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    clkfrac_accum u_acc (
      .clk         (clk),
      .rst         (rst),
      .stop        (stop_w[i]),
      .ratio_pend  (ratio_w[i]),
      .en_o        (ref_en[i]),
      .ratio_act_o (act_w[i])
    );
  end
endmodule

// File: rtl/clkfrac_chk.sv
module clkfrac_chk #(
  parameter int NUM_OUT = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_we,
  input logic [NUM_OUT-1:0]         cfg_be,
  input logic [NUM_OUT*8-1:0]       cfg_wdata,
  input logic [NUM_OUT*8-1:0]       cfg_rdata,
  input logic [NUM_OUT-1:0]         ref_en,
  input logic [NUM_OUT-1:0]         range_err,
  input logic [NUM_OUT-1:0]         stop_w,
  input logic [NUM_OUT-1:0][5:0]    act_w
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      ref_en[i] |-> !$past(stop_w[i]));

    assert_no_double_gap_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(stop_w[i], 2) && !$past(stop_w[i]) && !$past(ref_en[i])) |-> ref_en[i]);

    assert_ratio_switch_on_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(act_w[i]) |-> ref_en[i]);

    assert_readback_legal_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_rdata[i*8 +: 6] >= 6'd18) && (cfg_rdata[i*8 +: 6] <= 6'd35) && !cfg_rdata[i*8+6]);

    assert_err_follows_write_R7: assert property (@(posedge clk) disable iff (rst)
      $past(cfg_we && cfg_be[i]) |->
        (range_err[i] == (($past(cfg_wdata[i*8 +: 6]) < 6'd18) || ($past(cfg_wdata[i*8 +: 6]) > 6'd35))));

    assert_unselected_byte_kept_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(cfg_we && cfg_be[i]) |-> ($stable(cfg_rdata[i*8 +: 8]) && $stable(range_err[i])));
  end
endmodule

bind clkfrac_top clkfrac_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .ref_en    (ref_en),
  .range_err (range_err),
  .stop_w    (stop_w),
  .act_w     (act_w)
);

// File: tb/clkfrac_top_tb.sv
`timescale 1ns/1ps
module clkfrac_top_tb;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [N-1:0]   cfg_be = '0;
  logic [N*8-1:0] cfg_wdata = '0;
  logic [N*8-1:0] cfg_rdata;
  logic [N-1:0]   ref_en;
  logic [N-1:0]   range_err;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  clkfrac_top #(.NUM_OUT(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ref_en(ref_en), .range_err(range_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; outputs sampled there show the
  // result of the rising edge just passed.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [N-1:0] b, input logic [N*8-1:0] d);
    cfg_we = 1'b1; cfg_be = b; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  function automatic logic [7:0] fld(input bit stop, input int r);
    return {stop, 1'b0, 6'(r)};
  endfunction

  function automatic int clampv(input int r);
    return (r < 18) ? 18 : ((r > 35) ? 35 : r);
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [N*8-1:0] d;
    repeat (4) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check(cfg_rdata == {N{8'h92}}, "R1 readback", int'(cfg_rdata), int'({N{8'h92}}));
    check(ref_en == '0, "R1 ref_en", int'(ref_en), 0);
    check(range_err == '0, "R1 range_err", int'(range_err), 0);

    // R9: ratio 18 from reset, then switch to 35
    wr(4'b0001, {N{fld(0, 18)}});
    check(ref_en[0] == 1'b0, "R8 first edge still stopped", ref_en[0], 0);
    tick(); check(ref_en[0] == 1'b1, "R4 full rate", ref_en[0], 1);
    tick(); check(ref_en[0] == 1'b1, "R4 full rate", ref_en[0], 1);
    check(cfg_rdata[31:8] == {3{8'h92}}, "R2 unselected bytes kept", int'(cfg_rdata[31:8]), int'({3{8'h92}}));
    wr(4'b0001, {N{fld(0, 35)}});
    check(ref_en[0] == 1'b1, "R9 write edge", ref_en[0], 1);
    tick(); check(ref_en[0] == 1'b1, "R9 old ratio until pulse", ref_en[0], 1);
    tick(); check(ref_en[0] == 1'b0, "R9 new ratio gap", ref_en[0], 0);
    tick(); check(ref_en[0] == 1'b1, "R9 new ratio pulse", ref_en[0], 1);

    // R8: phase hold across a stop at ratio 30
    wr(4'b0001, {N{fld(0, 30)}});
    repeat (5) tick();
    cnt = 0;
    for (int k = 0; k < 12; k++) begin tick(); cnt += ref_en[0]; end
    wr(4'b0001, {N{fld(1, 30)}});
    cnt += ref_en[0];
    for (int k = 0; k < 10; k++) begin
      tick(); check(ref_en[0] == 1'b0, "R8 stopped output low", ref_en[0], 0);
    end
    wr(4'b0001, {N{fld(0, 30)}});
    check(ref_en[0] == 1'b0, "R8 stopped at release edge", ref_en[0], 0);
    for (int k = 0; k < 17; k++) begin tick(); cnt += ref_en[0]; end
    check(cnt == 18, "R8 pulses across stop", cnt, 18);

    // Sweep every ratio code on all channels
    for (int f = 0; f < 64; f++) begin
      int code [N];
      int eff [N];
      int pc [N];
      bit gap [N];
      bit prev [N];
      for (int i = 0; i < N; i++) begin
        code[i] = (f + 13 * i) % 64;
        eff[i]  = clampv(code[i]);
        d[i*8 +: 8] = fld(1, code[i]);
      end
      wr('1, d);
      for (int i = 0; i < N; i++) begin
        check(cfg_rdata[i*8 +: 8] == fld(1, eff[i]), "R6 clamped readback",
              int'(cfg_rdata[i*8 +: 8]), int'(fld(1, eff[i])));
        check(range_err[i] == (code[i] != eff[i]), "R7 range flag",
              range_err[i], int'(code[i] != eff[i]));
        d[i*8 +: 8] = fld(0, code[i]);
      end
      wr('1, d);
      check(ref_en == '0, "R8 stopped edge", int'(ref_en), 0);
      repeat (3) tick();
      for (int i = 0; i < N; i++) begin pc[i] = 0; gap[i] = 0; prev[i] = 1; end
      for (int k = 0; k < 35; k++) begin
        tick();
        for (int i = 0; i < N; i++) begin
          if (k < eff[i]) pc[i] += ref_en[i];
          if (!ref_en[i] && !prev[i]) gap[i] = 1;
          prev[i] = ref_en[i];
        end
      end
      for (int i = 0; i < N; i++) begin
        check(pc[i] == 18, (eff[i] == 18) ? "R4 every cycle" : "R3 pulses per window", pc[i], 18);
        check(!gap[i], "R5 no double gap", gap[i], 0);
      end
    end

    // R7: flag holds across writes to other bytes, clears on legal write
    wr(4'b0001, {N{fld(1, 5)}});
    check(range_err[0] == 1'b1, "R7 flag set", range_err[0], 1);
    wr(4'b0010, {N{fld(1, 20)}});
    check(range_err[0] == 1'b1, "R7 flag held", range_err[0], 1);
    check(cfg_rdata[7:0] == fld(1, 18), "R2 byte0 kept", int'(cfg_rdata[7:0]), int'(fld(1, 18)));
    wr(4'b0001, {N{fld(1, 25)}});
    check(range_err[0] == 1'b0, "R7 flag cleared", range_err[0], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule